// File: doc/BRIEF.md
# Two-Stage Sinc Decimation Filter

This block turns a one-bit delta-sigma modulator stream into 24-bit signed conversion results. Each accepted modulator sample is qualified by a one-cycle strobe. A third-order sinc (CIC) decimator forms the first stage. A ten-point boxcar averager can follow it. A two-bit rate code chooses the first-stage ratio and decides whether the averager is in the path. When the strobe arrives once every 144 system clocks of a 7.3728 MHz clock, the four codes give output rates of 10, 100, 400 and 800 samples per second.

Every rate code except 00 bypasses the boxcar stage, so the first-stage output is scaled and saturated straight into the output register. Code 00 runs both stages. Any change of the rate code restarts the filter from a cleared state. The first one or two first-stage outputs after a restart are discarded because they are not yet settled. Each new result appears in the output register together with a one-cycle ready pulse, and the register holds its value at all other times.

The controller is a three-state machine:
- `ST_DROP_A` is entered on reset and on every restart. It discards the first first-stage output.
- `ST_DROP_B` discards the second first-stage output.
- `ST_RUN` passes every later first-stage output on.

The transitions are:
- **advance**: a first-stage output moves `ST_DROP_A` to `ST_DROP_B`, and `ST_DROP_B` to `ST_RUN`.
- **restart**: a rate-code change moves any state back to `ST_DROP_A`. Restart has priority over advance.

Top module: `sinc_decim`

## Requirements
- R1: After reset, `result` is 0 and `result_valid` is 0. The reset rate code is 00, so with `rate_sel` held at 00 from reset the first result follows the 6144th strobe.
- R2: A sample of 1 counts as +1 and a sample of 0 counts as -1. In the bypass codes the result is sat24(v·2^(23−3·log2 R)), where v is the settled sinc3 output (R³ times the input mean). For example, a repeating 1,1,1,0 stream gives 0x400000 and an alternating stream gives 0.
- R3: The codes select the following paths:
  - 00: sinc3 by 512, then the boxcar by 10 (5120 strobes between results).
  - 01: sinc3 by 512 (512 strobes).
  - 10: sinc3 by 128 (128 strobes).
  - 11: sinc3 by 64 (64 strobes).
- R4: With code 00, the result is sat24((S·13108) >>> 21), where S is the sum of ten consecutive settled sinc3 outputs. A repeating 1,1,1,0 stream therefore gives 0x400100.
- R5: sat24 clamps values above 8388607 to 0x7FFFFF and values below −8388608 to 0x800000. All ones gives 0x7FFFFF and all zeros gives 0x800000 in every code.
- R6: `result_valid` is never high for two cycles in a row. `result` changes only in a cycle where `result_valid` is high.
- R7: A rate-code change clears the filter state, and the strobe in the same cycle is discarded. The first result then follows the 3R-th later strobe in a bypass code, or the 6144th in code 00. No pulse occurs in the cycle after the change.
- R8: A restart leaves the last result in `result` until the next pulse.
- R9: Two results are never fewer than 64 strobes apart. Under code 00 they are never fewer than 5120 strobes apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Rate code (see R3) |
| mod_valid | input | 1 | One-cycle strobe qualifying `mod_bit` |
| mod_bit | input | 1 | Modulator sample |
| result | output | 24 | Signed conversion result |
| result_valid | output | 1 | One-cycle pulse marking a new `result` |

## Verification
A rate-code change and an input strobe can fall in the same cycle. In that case the restart must win and the strobe must be dropped. The bench provokes this by raising `rate_sel` and `mod_valid` on the same clock. It then counts the later strobes up to the first pulse: 384 shows the strobe was dropped, and 383 would show it had leaked into the cleared filter. A restart can also coincide with a first-stage output that is already in flight. That output must not reach `result`, which the checker judges by requiring a silent `result_valid` in the cycle after any change.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;

    localparam int OUT_W  = 24;
    localparam int WIDE_W = 48;

    typedef enum logic [1:0] {
        RATE_TWO = 2'b00,
        RATE_HI  = 2'b01,
        RATE_MID = 2'b10,
        RATE_LO  = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        ST_DROP_A,
        ST_DROP_B,
        ST_RUN
    } ctl_state_e;

    // Clamp a wide signed value into the signed output range.
    function automatic logic [OUT_W-1:0] sat_out(input logic signed [WIDE_W-1:0] v);
        logic signed [WIDE_W-1:0] hi;
        logic signed [WIDE_W-1:0] lo;
        hi = WIDE_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
        lo = -hi - WIDE_W'(1);
        if (v > hi) begin
            return {1'b0, {(OUT_W-1){1'b1}}};
        end else if (v < lo) begin
            return {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            return v[OUT_W-1:0];
        end
    endfunction

endpackage

// File: rtl/sinc_decim_ctrl.sv
module sinc_decim_ctrl
    import sinc_decim_pkg::*;
#(
    parameter int DEC_LO  = 64,
    parameter int DEC_MID = 128,
    parameter int DEC_HI  = 512,
    parameter int CNT_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel,
    input  logic             y_valid,
    output logic             clr,
    output logic             keep,
    output rate_e            rate_cur,
    output logic [CNT_W-1:0] ratio_m1
);

    rate_e      rate_q;
    ctl_state_e st_q;
    ctl_state_e st_d;
    logic       change;

    assign change   = (rate_sel != rate_q);
    assign rate_cur = rate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_TWO;
        end else begin
            rate_q <= rate_e'(rate_sel);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_DROP_A;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: restart outranks advance
    always_comb begin
        st_d = st_q;
        if (change) begin
            st_d = ST_DROP_A;
        end else if (y_valid) begin
            unique case (st_q)
                ST_DROP_A: st_d = ST_DROP_B;
                ST_DROP_B: st_d = ST_RUN;
                ST_RUN:    st_d = ST_RUN;
                default:   st_d = ST_DROP_A;
            endcase
        end
    end

    // outputs
    always_comb begin
        clr  = change;
        keep = y_valid && !change && (st_q == ST_RUN);
        unique case (rate_q)
            RATE_TWO, RATE_HI: ratio_m1 = CNT_W'(DEC_HI - 1);
            RATE_MID:          ratio_m1 = CNT_W'(DEC_MID - 1);
            default:           ratio_m1 = CNT_W'(DEC_LO - 1);
        endcase
    end

endmodule

// File: rtl/sinc_decim_cic.sv
module sinc_decim_cic #(
    parameter int ORDER = 3,
    parameter int ACC_W = 29,
    parameter int CNT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    in_valid,
    input  logic                    in_bit,
    input  logic [CNT_W-1:0]        ratio_m1,
    output logic signed [ACC_W-1:0] y,
    output logic                    y_valid
);

    logic signed [ACC_W-1:0] integ_q [ORDER];
    logic signed [ACC_W-1:0] integ_n [ORDER];
    logic signed [ACC_W-1:0] dly_q   [ORDER];
    logic signed [ACC_W-1:0] comb_in [ORDER];
    logic signed [ACC_W-1:0] comb_out;
    logic [CNT_W-1:0]        cnt_q;
    logic                    dec_now;

    assign dec_now = in_valid && (cnt_q == ratio_m1);

    // integrator chain, settled in one cycle per sample
    always_comb begin
        logic signed [ACC_W-1:0] s;
        s = in_bit ? ACC_W'(1) : -ACC_W'(1);
        for (int k = 0; k < ORDER; k++) begin
            integ_n[k] = integ_q[k] + s;
            s          = integ_n[k];
        end
    end

    // comb chain at the decimated rate
    always_comb begin
        logic signed [ACC_W-1:0] c;
        c = integ_n[ORDER-1];
        for (int k = 0; k < ORDER; k++) begin
            comb_in[k] = c;
            c          = c - dly_q[k];
        end
        comb_out = c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < ORDER; k++) begin
                integ_q[k] <= '0;
                dly_q[k]   <= '0;
            end
            cnt_q   <= '0;
            y       <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= 1'b0;
            if (in_valid) begin
                for (int k = 0; k < ORDER; k++) begin
                    integ_q[k] <= integ_n[k];
                end
                if (dec_now) begin
                    cnt_q <= '0;
                    for (int k = 0; k < ORDER; k++) begin
                        dly_q[k] <= comb_in[k];
                    end
                    y       <= comb_out;
                    y_valid <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sinc_decim_post.sv
module sinc_decim_post
    import sinc_decim_pkg::*;
#(
    parameter int ORDER     = 3,
    parameter int ACC_W     = 29,
    parameter int DEC_LO    = 64,
    parameter int DEC_MID   = 128,
    parameter int DEC_HI    = 512,
    parameter int BOX_N     = 10,
    parameter int BOX_MUL   = 13108,
    parameter int BOX_SHIFT = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    keep,
    input  rate_e                   rate,
    input  logic signed [ACC_W-1:0] y,
    output logic [OUT_W-1:0]        result,
    output logic                    result_valid
);

    localparam int BOX_CW = $clog2(BOX_N);
    localparam int BOX_W  = ACC_W + BOX_CW + 1;
    localparam int SH_LO  = OUT_W - 1 - ORDER * $clog2(DEC_LO);
    localparam int SH_MID = OUT_W - 1 - ORDER * $clog2(DEC_MID);
    localparam int SH_HI  = OUT_W - 1 - ORDER * $clog2(DEC_HI);

    logic signed [BOX_W-1:0]  box_acc;
    logic signed [BOX_W-1:0]  box_sum;
    logic [BOX_CW-1:0]        box_cnt;
    logic signed [WIDE_W-1:0] ext;
    logic signed [WIDE_W-1:0] by_scaled;
    logic signed [WIDE_W-1:0] box_scaled;
    int                       sh;

    assign box_sum = box_acc + BOX_W'(y);
    assign ext     = WIDE_W'(y);

    always_comb begin
        unique case (rate)
            RATE_MID: sh = SH_MID;
            RATE_LO:  sh = SH_LO;
            default:  sh = SH_HI;
        endcase
        if (sh >= 0) begin
            by_scaled = ext <<< sh;
        end else begin
            by_scaled = ext >>> (-sh);
        end
        box_scaled = (WIDE_W'(box_sum) * WIDE_W'(BOX_MUL)) >>> BOX_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
            box_acc      <= '0;
            box_cnt      <= '0;
        end else begin
            result_valid <= 1'b0;
            if (clr) begin
                box_acc <= '0;
                box_cnt <= '0;
            end else if (keep) begin
                if (rate == RATE_TWO) begin
                    if (box_cnt == BOX_CW'(BOX_N - 1)) begin
                        result       <= sat_out(box_scaled);
                        result_valid <= 1'b1;
                        box_acc      <= '0;
                        box_cnt      <= '0;
                    end else begin
                        box_acc <= box_sum;
                        box_cnt <= box_cnt + BOX_CW'(1);
                    end
                end else begin
                    result       <= sat_out(by_scaled);
                    result_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
    import sinc_decim_pkg::*;
#(
    parameter int ORDER     = 3,
    parameter int DEC_LO    = 64,
    parameter int DEC_MID   = 128,
    parameter int DEC_HI    = 512,
    parameter int BOX_N     = 10,
    parameter int BOX_MUL   = 13108,
    parameter int BOX_SHIFT = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel,
    input  logic             mod_valid,
    input  logic             mod_bit,
    output logic [OUT_W-1:0] result,
    output logic             result_valid
);

    localparam int CNT_W = $clog2(DEC_HI);
    localparam int ACC_W = ORDER * CNT_W + 2;

    logic                    clr;
    logic                    keep;
    rate_e                   rate_cur;
    logic [CNT_W-1:0]        ratio_m1;
    logic signed [ACC_W-1:0] y;
    logic                    y_valid;

    sinc_decim_ctrl #(
        .DEC_LO (DEC_LO),
        .DEC_MID(DEC_MID),
        .DEC_HI (DEC_HI),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_sel(rate_sel),
        .y_valid (y_valid),
        .clr     (clr),
        .keep    (keep),
        .rate_cur(rate_cur),
        .ratio_m1(ratio_m1)
    );

    sinc_decim_cic #(
        .ORDER(ORDER),
        .ACC_W(ACC_W),
        .CNT_W(CNT_W)
    ) u_cic (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .in_valid(mod_valid),
        .in_bit  (mod_bit),
        .ratio_m1(ratio_m1),
        .y       (y),
        .y_valid (y_valid)
    );

    sinc_decim_post #(
        .ORDER    (ORDER),
        .ACC_W    (ACC_W),
        .DEC_LO   (DEC_LO),
        .DEC_MID  (DEC_MID),
        .DEC_HI   (DEC_HI),
        .BOX_N    (BOX_N),
        .BOX_MUL  (BOX_MUL),
        .BOX_SHIFT(BOX_SHIFT)
    ) u_post (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .keep        (keep),
        .rate        (rate_cur),
        .y           (y),
        .result      (result),
        .result_valid(result_valid)
    );

endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
    parameter int DEC_LO = 64,
    parameter int DEC_HI = 512,
    parameter int BOX_N  = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  rate_sel,
    input logic        mod_valid,
    input logic [23:0] result,
    input logic        result_valid
);

    logic [1:0]  prev_rate;
    logic [31:0] gap;

    // strobes seen since the last pulse or restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rate <= 2'b00;
            gap       <= '0;
        end else begin
            prev_rate <= rate_sel;
            if (rate_sel != prev_rate) begin
                gap <= '0;
            end else if (result_valid) begin
                gap <= mod_valid ? 32'd1 : 32'd0;
            end else if (mod_valid) begin
                gap <= gap + 32'd1;
            end
        end
    end

    // R6: one-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R6: output register holds between pulses
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    // R7: no pulse right after a restart
    a_r7_quiet_after_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != prev_rate) |=> !result_valid);

    // R9: minimum spacing of results
    a_r9_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (gap >= 32'(DEC_LO)));

    // R3: two-stage spacing
    a_r3_two_stage_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && rate_sel == 2'b00 && rate_sel == prev_rate)
            |-> (gap >= 32'(DEC_HI * BOX_N)));

endmodule

bind sinc_decim sinc_decim_chk #(
    .DEC_LO(DEC_LO),
    .DEC_HI(DEC_HI),
    .BOX_N (BOX_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .mod_valid   (mod_valid),
    .result      (result),
    .result_valid(result_valid)
);

// File: tb/sinc_decim_tb.sv
`timescale 1ns/1ps
module sinc_decim_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  rate_sel;
    logic        mod_valid;
    logic        mod_bit;
    logic [23:0] result;
    logic        result_valid;

    always #2 clk = ~clk;

    sinc_decim u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel    (rate_sel),
        .mod_valid   (mod_valid),
        .mod_bit     (mod_bit),
        .result      (result),
        .result_valid(result_valid)
    );

    // {rate[1:0], pattern[1:0], first gap[15:0], next gap[15:0]}
    // pattern: 0 ones, 1 zeros, 2 alternating, 3 repeating 1,1,1,0
    localparam logic [35:0] VEC [16] = '{
        {2'd0, 2'd0, 16'd6144, 16'd5120}, {2'd0, 2'd1, 16'd6144, 16'd5120},
        {2'd0, 2'd2, 16'd6144, 16'd5120}, {2'd0, 2'd3, 16'd6144, 16'd5120},
        {2'd1, 2'd0, 16'd1536, 16'd512},  {2'd1, 2'd1, 16'd1536, 16'd512},
        {2'd1, 2'd2, 16'd1536, 16'd512},  {2'd1, 2'd3, 16'd1536, 16'd512},
        {2'd2, 2'd0, 16'd384,  16'd128},  {2'd2, 2'd1, 16'd384,  16'd128},
        {2'd2, 2'd2, 16'd384,  16'd128},  {2'd2, 2'd3, 16'd384,  16'd128},
        {2'd3, 2'd0, 16'd192,  16'd64},   {2'd3, 2'd1, 16'd192,  16'd64},
        {2'd3, 2'd2, 16'd192,  16'd64},   {2'd3, 2'd3, 16'd192,  16'd64}
    };

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    int          mon_strobes = 0;
    int          mon_pulses = 0;
    int          mon_gap [2];
    logic [23:0] mon_val [2];
    int          hold_err = 0;
    int          width_err = 0;
    logic        prev_valid = 1'b0;
    logic [23:0] prev_res = '0;

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (mod_valid) mon_strobes++;
            if (result_valid) begin
                if (mon_pulses < 2) begin
                    mon_gap[mon_pulses] = mon_strobes;
                    mon_val[mon_pulses] = result;
                end
                mon_pulses++;
                mon_strobes = 0;
                if (prev_valid) width_err++;
            end else if (result !== prev_res) begin
                hold_err++;
            end
            prev_valid = result_valid;
            prev_res   = result;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit pat_bit(input int p, input int idx);
        case (p)
            0: return 1'b1;
            1: return 1'b0;
            2: return (idx % 2) == 0;
            default: return (idx % 4) != 3;
        endcase
    endfunction

    function automatic int pat_mean2(input int p);
        case (p)
            0: return 2;
            1: return -2;
            2: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic logic [23:0] exp_val(input logic [1:0] r, input int mean2);
        longint rr, v, e;
        int lg;
        case (r)
            2'd0, 2'd1: begin rr = 512; lg = 9; end
            2'd2:       begin rr = 128; lg = 7; end
            default:    begin rr = 64;  lg = 6; end
        endcase
        v = rr * rr * rr * longint'(mean2) / 2;
        if (r == 2'd0)             e = (10 * v * 13108) >>> 21;
        else if (23 - 3 * lg >= 0) e = v <<< (23 - 3 * lg);
        else                       e = v >>> (3 * lg - 23);
        if (e > 64'sd8388607)       return 24'h7FFFFF;
        else if (e < -64'sd8388608) return 24'h800000;
        else                        return e[23:0];
    endfunction

    task automatic clear_mon();
        mon_strobes = 0;
        mon_pulses  = 0;
    endtask

    task automatic drive(input int p, input int want_pulses, input int limit);
        int idx = 0;
        while (mon_pulses < want_pulses && idx < limit) begin
            @(negedge clk);
            mod_valid = 1'b1;
            mod_bit   = pat_bit(p, idx);
            idx++;
            @(negedge clk);
            mod_valid = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; rate_sel = 2'b00; mod_valid = 1'b0; mod_bit = 1'b0;
        repeat (5) @(negedge clk);
        chk(result == 24'h0, "R1", "reset result", result, 0);
        chk(result_valid == 1'b0, "R1", "reset valid", result_valid, 0);
        rst_n = 1'b1;
        clear_mon();

        // R1: default code 00 runs both stages
        drive(0, 1, 8000);
        chk(mon_gap[0] == 6144, "R1", "default-code first gap", mon_gap[0], 6144);
        chk(mon_val[0] == 24'h7FFFFF, "R1", "default-code value", mon_val[0], 24'h7FFFFF);

        // table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < 16; i++) begin
            logic [1:0] r;
            int p;
            logic [23:0] e;
            r = VEC[i][35:34];
            p = int'(VEC[i][33:32]);
            e = exp_val(r, pat_mean2(p));
            @(negedge clk); rate_sel = r ^ 2'b01;
            @(negedge clk); rate_sel = r;
            @(negedge clk); clear_mon();
            drive(p, 2, 13000);
            chk(mon_pulses >= 2, "R3", "pulses seen", mon_pulses, 2);
            chk(mon_gap[0] == int'(VEC[i][31:16]), "R7", "settle gap", mon_gap[0], VEC[i][31:16]);
            chk(mon_gap[1] == int'(VEC[i][15:0]), "R3", "result gap", mon_gap[1], VEC[i][15:0]);
            chk(mon_val[0] == e, (r == 2'd0) ? "R4" : "R2", "first value", mon_val[0], e);
            chk(mon_val[1] == e, (p < 2) ? "R5" : "R2", "second value", mon_val[1], e);
        end

        // R7: rate change coinciding with a strobe drops that strobe
        @(negedge clk); rate_sel = 2'b10; mod_valid = 1'b1; mod_bit = 1'b1;
        @(negedge clk); mod_valid = 1'b0; clear_mon();
        drive(0, 1, 1000);
        chk(mon_gap[0] == 384, "R7", "gap after coincident change", mon_gap[0], 384);
        chk(mon_val[0] == 24'h7FFFFF, "R5", "saturated high", mon_val[0], 24'h7FFFFF);

        // R8: restart leaves the previous result in place
        @(negedge clk); rate_sel = 2'b00;
        @(negedge clk); clear_mon();
        drive(1, 1, 1000);
        chk(mon_pulses == 0, "R8", "no early pulse after restart", mon_pulses, 0);
        chk(result == 24'h7FFFFF, "R8", "result held", result, 24'h7FFFFF);

        chk(width_err == 0, "R6", "multi-cycle pulses", width_err, 0);
        chk(hold_err == 0, "R6", "changes without pulse", hold_err, 0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule